// File: doc/BRIEF.md
# Voltage-Ordered Current Space Vector Sequencer

This block drives the six switches of one three-phase current source bridge. A repeating switching period is divided into three timed segments: two adjacent active current vectors and one zero vector. At the boundary of every period the block samples a sector number, the dwell counts of the two active vectors and three signed line-to-line voltage samples. For each of the three candidate vectors it derives the dc-side voltage that vector would present. It then plays the vectors back in order of falling dc-side voltage. When a rectifier bridge and an inverter bridge both use this block, each bridge follows the same large-to-small ordering. Their dc-side voltages then track each other across the period, which keeps the ripple in the shared dc-link inductor small, and no extra switch transitions are needed for this.

The dwell counts come from an external modulator. The block only orders, clips and times them. A one-cycle period strobe and a segment index are brought out so that the sequence can be observed from outside.

Top module: `cur_svm_seq`

## Requirements
- R1: In every cycle, including during and after reset, exactly one upper switch and exactly one lower switch are on. Gate bit i drives switch S(i+1): bits 0, 2 and 4 are S1, S3 and S5 (upper); bits 3, 5 and 1 are S4, S6 and S2 (lower). Reset holds S1 and S4.
- R2: `period_start_o` is high for one cycle at the first cycle of each period and repeats every PERIOD_CNT cycles.
- R3: In sector k (1..6) the active vectors are Ik and I((k mod 6)+1), with pairs I1=S1,S6; I2=S1,S2; I3=S3,S2; I4=S3,S4; I5=S5,S4; I6=S5,S6. The zero vector is the phase-leg short that contains the switch both active vectors share: I7=S1,S4 in sectors 1 and 4, I9=S5,S2 in sectors 2 and 5, I8=S3,S6 in sectors 3 and 6.
- R4: The dc-side voltages are vab, vac, vbc, -vab, -vac and -vbc for I1 through I6, and zero for I7, I8 and I9. Segments are played in descending order of that voltage, and each of the six possible orders occurs.
- R5: When voltages are equal, the first active vector comes before the second, and the second comes before the zero vector.
- R6: Each segment lasts exactly its dwell count. The zero dwell is PERIOD_CNT minus the two active dwells. `seg_idx_o` gives the playback slot (0, 1, 2), never decreases within a period, and the gates stay constant while it is unchanged.
- R7: A segment with a dwell of zero is skipped. Its gates never appear and its slot index is passed over.
- R8: The first active dwell is clipped to PERIOD_CNT. The second active dwell is clipped to what remains of the period, which leaves a zero dwell of zero.
- R9: Inputs are sampled only at the period boundary. Changes made during a period do not alter that period's output.
- R10: A sector code of 0 or 7 holds I7 (S1,S4) for the whole period, with `seg_idx_o` at 2.
- R11: Full-scale negative voltage samples negate without overflow. For example, -vab at the most negative sample ranks above every other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_i | input | 3 | Sector number 1..6, sampled at the period boundary |
| dwell_a_i | input | CNT_W | Dwell of first active vector, in clocks |
| dwell_b_i | input | CNT_W | Dwell of second active vector, in clocks |
| vab_i | input | V_W | Signed line voltage a-b |
| vac_i | input | V_W | Signed line voltage a-c |
| vbc_i | input | V_W | Signed line voltage b-c |
| gate_o | output | 6 | Switch gates, bit i drives S(i+1) |
| seg_idx_o | output | 2 | Current playback slot 0..2 |
| period_start_o | output | 1 | High in the first cycle of each period |

## Verification
The assertions check the structural properties on every cycle: one upper and one lower switch are on, the period strobe has a fixed spacing, the slot index rises monotonically within a period, and the gates are steady inside a slot. Only the bench scenarios can show that the right vectors come out for each sector, that the voltage ordering holds (including ties and full-scale negation), that segment lengths are correct after clipping, and that empty segments and invalid sectors are handled. The bench does this by comparing whole periods against a model of its own.

// File: rtl/cur_svm_pkg.sv
package cur_svm_pkg;

  typedef logic [3:0] vec_t;

  localparam vec_t VEC_Z14 = 4'd7;  // S1,S4 leg short
  localparam vec_t VEC_Z36 = 4'd8;  // S3,S6 leg short
  localparam vec_t VEC_Z25 = 4'd9;  // S5,S2 leg short

  localparam logic [5:0] UPPER_MASK = 6'b010101;
  localparam logic [5:0] LOWER_MASK = 6'b101010;

  // bit i of the gate word drives switch S(i+1)
  function automatic logic [5:0] vec_gates(input vec_t v);
    case (v)
      4'd1:    return 6'b100001;
      4'd2:    return 6'b000011;
      4'd3:    return 6'b000110;
      4'd4:    return 6'b001100;
      4'd5:    return 6'b011000;
      4'd6:    return 6'b110000;
      4'd8:    return 6'b100100;
      4'd9:    return 6'b010010;
      default: return 6'b001001;
    endcase
  endfunction

endpackage

// File: rtl/cur_svm_vecsel.sv
module cur_svm_vecsel
  import cur_svm_pkg::*;
#(
  parameter int PERIOD_CNT = 5000,
  parameter int CNT_W      = 13,
  parameter int V_W        = 16
) (
  input  logic [2:0]             sector_i,
  input  logic [CNT_W-1:0]       dwell_a_i,
  input  logic [CNT_W-1:0]       dwell_b_i,
  input  logic signed [V_W-1:0]  vab_i,
  input  logic signed [V_W-1:0]  vac_i,
  input  logic signed [V_W-1:0]  vbc_i,
  output vec_t                   vec_o  [3],
  output logic signed [V_W:0]    volt_o [3],
  output logic [CNT_W-1:0]       len_o  [3]
);

  localparam logic [CNT_W-1:0] P_C = CNT_W'(PERIOD_CNT);

  logic signed [V_W:0] ab, ac, bc;
  logic                valid;
  logic [CNT_W-1:0]    da, db, rem;

  assign ab = {vab_i[V_W-1], vab_i};
  assign ac = {vac_i[V_W-1], vac_i};
  assign bc = {vbc_i[V_W-1], vbc_i};
  assign valid = (sector_i != 3'd0) && (sector_i != 3'd7);

  function automatic logic signed [V_W:0] dc_volt(input vec_t v);
    case (v)
      4'd1:    return ab;
      4'd2:    return ac;
      4'd3:    return bc;
      4'd4:    return -ab;
      4'd5:    return -ac;
      4'd6:    return -bc;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    if (valid) begin
      vec_o[0] = vec_t'(sector_i);
      vec_o[1] = (sector_i == 3'd6) ? 4'd1 : vec_t'(sector_i + 3'd1);
      case (sector_i)
        3'd2, 3'd5: vec_o[2] = VEC_Z25;
        3'd3, 3'd6: vec_o[2] = VEC_Z36;
        default:    vec_o[2] = VEC_Z14;
      endcase
    end else begin
      vec_o[0] = VEC_Z14;
      vec_o[1] = VEC_Z14;
      vec_o[2] = VEC_Z14;
    end
    for (int i = 0; i < 3; i++) volt_o[i] = dc_volt(vec_o[i]);

    da  = (dwell_a_i > P_C) ? P_C : dwell_a_i;
    rem = P_C - da;
    db  = (dwell_b_i > rem) ? rem : dwell_b_i;
    if (valid) begin
      len_o[0] = da;
      len_o[1] = db;
      len_o[2] = rem - db;
    end else begin
      len_o[0] = '0;
      len_o[1] = '0;
      len_o[2] = P_C;
    end
  end

endmodule

// File: rtl/cur_svm_rank.sv
module cur_svm_rank #(
  parameter int W = 17
) (
  input  logic signed [W-1:0] volt_i [3],
  output logic [5:0]          pos_o
);

  // position of entry i = number of entries placed ahead of it;
  // a lower index wins a tie
  for (genvar i = 0; i < 3; i++) begin : g_rank
    logic [2:0] ahead;
    for (genvar j = 0; j < 3; j++) begin : g_cmp
      if (j == i) begin : g_self
        assign ahead[j] = 1'b0;
      end else if (j < i) begin : g_lo
        assign ahead[j] = (volt_i[j] >= volt_i[i]);
      end else begin : g_hi
        assign ahead[j] = (volt_i[j] > volt_i[i]);
      end
    end
    assign pos_o[2*i +: 2] = 2'(ahead[0]) + 2'(ahead[1]) + 2'(ahead[2]);
  end

endmodule

// File: rtl/cur_svm_seq.sv
module cur_svm_seq
  import cur_svm_pkg::*;
#(
  parameter int  PERIOD_CNT = 5000,
  parameter int  V_W        = 16,
  localparam int CNT_W      = $clog2(PERIOD_CNT + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            sector_i,
  input  logic [CNT_W-1:0]      dwell_a_i,
  input  logic [CNT_W-1:0]      dwell_b_i,
  input  logic signed [V_W-1:0] vab_i,
  input  logic signed [V_W-1:0] vac_i,
  input  logic signed [V_W-1:0] vbc_i,
  output logic [5:0]            gate_o,
  output logic [1:0]            seg_idx_o,
  output logic                  period_start_o
);

  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PERIOD_CNT - 1);

  vec_t                cand_vec  [3];
  logic signed [V_W:0] cand_volt [3];
  logic [CNT_W-1:0]    cand_len  [3];
  logic [5:0]          pos;

  cur_svm_vecsel #(.PERIOD_CNT(PERIOD_CNT), .CNT_W(CNT_W), .V_W(V_W)) u_vecsel (
    .sector_i (sector_i),
    .dwell_a_i(dwell_a_i),
    .dwell_b_i(dwell_b_i),
    .vab_i    (vab_i),
    .vac_i    (vac_i),
    .vbc_i    (vbc_i),
    .vec_o    (cand_vec),
    .volt_o   (cand_volt),
    .len_o    (cand_len)
  );

  cur_svm_rank #(.W(V_W + 1)) u_rank (
    .volt_i(cand_volt),
    .pos_o (pos)
  );

  // period state
  logic [CNT_W-1:0] pcnt;
  vec_t             slot_q [3];
  logic [CNT_W-1:0] bnd1_q, bnd2_q;

  // reorder candidates into playback slots
  vec_t             ord_vec [3];
  logic [CNT_W-1:0] ord_len [3];

  always_comb begin
    for (int s = 0; s < 3; s++) begin
      ord_vec[s] = cand_vec[0];
      ord_len[s] = cand_len[0];
      for (int i = 0; i < 3; i++) begin
        if (pos[2*i +: 2] == 2'(s)) begin
          ord_vec[s] = cand_vec[i];
          ord_len[s] = cand_len[i];
        end
      end
    end
  end

  logic             start;
  logic [CNT_W-1:0] ncnt, use_b1, use_b2;
  logic [1:0]       nseg;
  vec_t             nvec;

  always_comb begin
    start  = (pcnt == P_LAST);
    ncnt   = start ? '0 : CNT_W'(pcnt + 1'b1);
    use_b1 = start ? ord_len[0] : bnd1_q;
    use_b2 = start ? CNT_W'(ord_len[0] + ord_len[1]) : bnd2_q;
    if (ncnt < use_b1)      nseg = 2'd0;
    else if (ncnt < use_b2) nseg = 2'd1;
    else                    nseg = 2'd2;
    nvec = start ? ord_vec[nseg] : slot_q[nseg];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt           <= P_LAST;
      bnd1_q         <= '0;
      bnd2_q         <= '0;
      for (int s = 0; s < 3; s++) slot_q[s] <= VEC_Z14;
      gate_o         <= vec_gates(VEC_Z14);
      seg_idx_o      <= 2'd2;
      period_start_o <= 1'b0;
    end else begin
      pcnt <= ncnt;
      if (start) begin
        bnd1_q <= use_b1;
        bnd2_q <= use_b2;
        for (int s = 0; s < 3; s++) slot_q[s] <= ord_vec[s];
      end
      gate_o         <= vec_gates(nvec);
      seg_idx_o      <= nseg;
      period_start_o <= start;
    end
  end

endmodule

// File: rtl/cur_svm_seq_chk.sv
module cur_svm_seq_chk
  import cur_svm_pkg::*;
#(
  parameter int PERIOD_CNT = 5000
) (
  input logic       clk,
  input logic       rst,
  input logic [5:0] gate_o,
  input logic [1:0] seg_idx_o,
  input logic       period_start_o
);

  logic [31:0] since;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (period_start_o) begin
      since <= '0;
      seen  <= 1'b1;
    end else begin
      since <= since + 32'd1;
    end
  end

  AST_ONE_UPPER: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_o & UPPER_MASK) == 1);  // R1
  AST_ONE_LOWER: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_o & LOWER_MASK) == 1);  // R1
  AST_START_DUE: assert property (@(posedge clk) disable iff (rst)
    (seen && since == 32'(PERIOD_CNT - 1)) |-> period_start_o);  // R2
  AST_START_SPACING: assert property (@(posedge clk) disable iff (rst)
    (seen && period_start_o) |-> since == 32'(PERIOD_CNT - 1));  // R2
  AST_SLOT_RISES: assert property (@(posedge clk) disable iff (rst)
    !period_start_o |-> seg_idx_o >= $past(seg_idx_o));  // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    seg_idx_o != 2'd3);  // R6
  AST_GATES_HELD: assert property (@(posedge clk) disable iff (rst)
    (!period_start_o && $stable(seg_idx_o)) |-> $stable(gate_o));  // R6

endmodule

bind cur_svm_seq cur_svm_seq_chk #(.PERIOD_CNT(PERIOD_CNT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .gate_o        (gate_o),
  .seg_idx_o     (seg_idx_o),
  .period_start_o(period_start_o)
);

// File: tb/cur_svm_seq_bench.sv
module cur_svm_seq_bench;

  localparam int P     = 40;
  localparam int V_W   = 16;
  localparam int CNT_W = $clog2(P + 1);
  localparam int N_T   = 14;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [2:0]            sector_i = 3'd1;
  logic [CNT_W-1:0]      dwell_a_i = '0, dwell_b_i = '0;
  logic signed [V_W-1:0] vab_i = '0, vac_i = '0, vbc_i = '0;
  logic [5:0]            gate_o;
  logic [1:0]            seg_idx_o;
  logic                  period_start_o;

  always #4 clk = ~clk;  // 125 MHz

  cur_svm_seq #(.PERIOD_CNT(P), .V_W(V_W)) u_cur_svm_seq (
    .clk(clk), .rst(rst), .sector_i(sector_i),
    .dwell_a_i(dwell_a_i), .dwell_b_i(dwell_b_i),
    .vab_i(vab_i), .vac_i(vac_i), .vbc_i(vbc_i),
    .gate_o(gate_o), .seg_idx_o(seg_idx_o), .period_start_o(period_start_o)
  );

  typedef struct {
    logic [5:0] g0, g1, g2;
    int         l0, l1, l2;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0, n_fail = 0, done = 0;
  bit   finished = 0;

  function automatic logic [5:0] pair_bits(input int code);
    int up, lo;
    case (code)
      1: begin up = 1; lo = 6; end
      2: begin up = 1; lo = 2; end
      3: begin up = 3; lo = 2; end
      4: begin up = 3; lo = 4; end
      5: begin up = 5; lo = 4; end
      6: begin up = 5; lo = 6; end
      8: begin up = 3; lo = 6; end
      9: begin up = 5; lo = 2; end
      default: begin up = 1; lo = 4; end
    endcase
    return 6'((1 << (up - 1)) | (1 << (lo - 1)));
  endfunction

  function automatic int volt_of(input int code, input int ab, input int ac, input int bc);
    case (code)
      1: return ab;   2: return ac;   3: return bc;
      4: return -ab;  5: return -ac;  6: return -bc;
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model(input int sec, input int a, input int b,
                                 input int ab, input int ac, input int bc, input string tag);
    exp_t e;
    int code[3], v[3], len[3], ord[3];
    bit taken[3];
    if (sec >= 1 && sec <= 6) begin
      code[0] = sec;
      code[1] = (sec % 6) + 1;
      code[2] = (sec == 1 || sec == 4) ? 7 : (sec == 2 || sec == 5) ? 9 : 8;
      if (a > P) a = P;
      if (a + b > P) b = P - a;
      len[0] = a; len[1] = b; len[2] = P - a - b;
    end else begin
      code[0] = 7; code[1] = 7; code[2] = 7;
      len[0] = 0; len[1] = 0; len[2] = P;
    end
    for (int i = 0; i < 3; i++) begin
      v[i] = volt_of(code[i], ab, ac, bc);
      taken[i] = 0;
    end
    for (int s = 0; s < 3; s++) begin
      int best;
      best = -1;
      for (int i = 0; i < 3; i++)
        if (!taken[i] && (best < 0 || v[i] > v[best])) best = i;
      ord[s] = best;
      taken[best] = 1;
    end
    e.g0 = pair_bits(code[ord[0]]); e.l0 = len[ord[0]];
    e.g1 = pair_bits(code[ord[1]]); e.l1 = len[ord[1]];
    e.g2 = pair_bits(code[ord[2]]); e.l2 = len[ord[2]];
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input int sec, input int a, input int b,
                       input int ab, input int ac, input int bc, input string tag);
    sector_i  = 3'(sec);
    dwell_a_i = CNT_W'(a);
    dwell_b_i = CNT_W'(b);
    vab_i = V_W'(ab); vac_i = V_W'(ac); vbc_i = V_W'(bc);
    exp_q.push_back(model(sec, a, b, ab, ac, bc, tag));
  endtask

  task automatic apply(input int t);
    case (t)
      0:  drive(1, 10, 8, 100, 50, -50, "R4/R6");
      1:  drive(1, 10, 8, -30, 60, 0, "R4/R9");
      2:  drive(2, 7, 9, 0, -20, -40, "R3");
      3:  drive(3, 12, 6, 50, 0, -60, "R3");
      4:  drive(4, 5, 5, -70, 30, 0, "R4");
      5:  drive(5, 9, 11, 0, -5, -90, "R4");
      6:  drive(6, 8, 8, 0, 0, 0, "R5");
      7:  drive(1, 0, 15, 100, 50, 0, "R7");
      8:  drive(1, 30, 25, 100, 50, 0, "R8");
      9:  drive(1, 50, 5, 100, 50, 0, "R8");
      10: drive(0, 5, 5, 100, 50, 0, "R10");
      11: drive(7, 5, 5, 100, 50, 0, "R10");
      12: drive(4, 10, 10, -32768, 100, 0, "R11");
      default: drive(2, 40, 0, 0, 10, 20, "R7");
    endcase
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  // monitor: pops one expected period per strobe, compares every cycle
  exp_t       cur;
  bit         have_cur = 0, bad = 0;
  int         cyc = 0;
  logic [5:0] bad_act, bad_exp;
  int         bad_cyc;

  always @(negedge clk) begin
    if (!rst) begin
      if (period_start_o) begin
        if (have_cur) begin
          n_checks++;
          if (cyc != P) begin
            n_fail++;
            $display("FAIL R2 period length: actual %0d expected %0d", cyc, P);
          end
          n_checks++;
          if (bad) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b",
                     cur.tag, bad_cyc, bad_act, bad_exp);
          end
          done++;
        end
        have_cur = (exp_q.size() > 0);
        if (have_cur) cur = exp_q.pop_front();
        cyc = 0;
        bad = 0;
      end
      if (have_cur) begin
        int         slot;
        logic [5:0] eg;
        slot = (cyc < cur.l0) ? 0 : (cyc < cur.l0 + cur.l1) ? 1 : 2;
        eg = (slot == 0) ? cur.g0 : (slot == 1) ? cur.g1 : cur.g2;
        if (!bad && (gate_o !== eg || seg_idx_o !== 2'(slot))) begin
          bad = 1;
          bad_cyc = cyc;
          bad_act = gate_o ^ {4'b0, seg_idx_o};
          bad_act = gate_o;
          bad_exp = eg;
          if (seg_idx_o !== 2'(slot)) begin
            bad_act = {4'b0, seg_idx_o};
            bad_exp = 6'(slot);
          end
        end
        cyc++;
      end
    end
  end

  // driver
  initial begin
    apply(0);
    repeat (3) @(negedge clk);
    n_checks++;
    if (gate_o !== 6'b001001 || period_start_o !== 1'b0 || seg_idx_o !== 2'd2) begin
      n_fail++;
      $display("FAIL R1 reset state: actual %b/%b/%0d expected 001001/0/2",
               gate_o, period_start_o, seg_idx_o);
    end
    rst = 1'b0;
    for (int t = 1; t < N_T; t++) begin
      @(negedge clk);
      while (!period_start_o) @(negedge clk);
      apply(t);
      // scramble nothing else mid-period: the new command waits for the boundary (R9)
    end
    wait (done == N_T);
    #1;
    finished = 1;
    summary();
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d periods expected %0d", done, N_T);
      summary();
      $finish;
    end
  end

endmodule